// File: doc/BRIEF.md
# Three-Port GPIO Register Bank

This block holds the configuration and output state for three general-purpose I/O ports. Ports 0 and 1 are 8 bits wide. Port 2 has 5 usable bits. A simple register bus reaches every register either as a whole byte or as a single bit. Each port has four registers:

- an output latch;
- a function-select register, which hands a pin to a peripheral or keeps it as plain I/O;
- a direction register;
- an input-mode register, which chooses between a pulled input and a tri-state input.

From these registers the bank drives the per-pin pad output enable, pad output value, pull enable and pull direction.

Pin levels pass through a two-flop synchronizer before software can read them. An ordinary read of a data register returns those synchronized levels. A read flagged as read-modify-write returns the output latch instead. This lets a bit update never copy an external level into the latch. One global register picks pull-up or pull-down for each port.

A low-power hold input freezes the pad drive. A two-state controller (`ST_RUN`, `ST_HOLD`) sits in `ST_RUN` until the hold input is sampled high. On that transition (run-to-hold) it captures the current pad enable and pad value. In `ST_HOLD` the pads show the captured values while the registers stay writable. When the hold input is sampled low, the transition hold-to-run makes the live values reach the pads again.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0. Every usable pin is an undriven input (pad_oe 0). Pull enable is high on every usable pin except port 1 bits 0 and 1. Pull direction is up (pull_up 1).
- R2: Register address: bus_addr[1:0] is the port (0..2) and bus_addr[3:2] is the kind (0 data latch, 1 function select, 2 direction, 3 input mode). Address 4'b0011 is the pull-polarity register. Any other address with port field 3 reads 0 and ignores writes. A byte write stores bus_wdata, and a read of a configuration register returns it on bus_rdata in the same cycle.
- R3: Port 2 bits 7..5 read as 0 in every register and ignore writes, whether byte or bit.
- R4: With bus_bit high, a write changes only bit bus_bit_idx, to bus_wdata[0]. A read with bus_bit high returns the selected bit in bus_rdata[0] and zeros above it.
- R5: With function select 0, a direction bit of 1 makes pad_oe 1 for that pin and a direction bit of 0 makes it 0. pad_out always follows the output latch.
- R6: With function select 1, pad_oe and pad_out of that pin follow periph_oe and periph_out. periph_in always equals pad_in.
- R7: A byte read of a data register without the read-modify-write flag returns pad_in, synchronized through two clock edges, whatever the pin configuration.
- R8: A data-register read with bus_rmw high returns the output latch, not the pin level.
- R9: Pull enable is high only on an input pin (pad_oe 0) whose input-mode bit is 0. An input-mode bit of 1 leaves the pin tri-state.
- R10: Port 1 bits 0 and 1 never have pull enable asserted.
- R11: Bit p of the pull-polarity register set to 1 selects pull-down for port p (pull_up 0 on its usable pins). Set to 0, it selects pull-up.
- R12: While hold_in is high, pad_oe and pad_out keep the values they had at the clock edge where hold_in was first sampled high. Register writes still take effect and can be read back. The live values reach the pads one edge after hold_in is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_bit | input | 1 | Single-bit access |
| bus_rmw | input | 1 | Read phase of a read-modify-write |
| bus_addr | input | 4 | {kind, port} register address |
| bus_bit_idx | input | 3 | Bit index for single-bit access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| hold_in | input | 1 | Low-power pad hold |
| pad_in | input | 24 | Pin levels, 8 per port |
| pad_oe | output | 24 | Pad output enable |
| pad_out | output | 24 | Pad output value |
| pull_en | output | 24 | Pad pull enable |
| pull_up | output | 24 | Pull direction, 1 = up |
| periph_oe | input | 24 | Peripheral output enable |
| periph_out | input | 24 | Peripheral output value |
| periph_in | output | 24 | Pin levels to peripherals |

## Verification
A corrupted latch, direction or select bit reaches pad_oe or pad_out in the same cycle as the faulty write. The same is true of pull_en for a wrong mode bit. Every bench write is therefore followed at once by a full comparison of all four pad vectors against a model. A fault in the synchronizer shows as a pin read that arrives too early or too late, so reads are taken both before and after the second edge. A hold controller stuck in the wrong state shows on the first edge after hold_in changes, as pads that either move during hold or fail to resume after release.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int NPORT  = 3;
    localparam int PW     = 8;
    localparam int LASTW  = 5;
    localparam int TOTAL  = NPORT * PW;
    localparam int IDXW   = $clog2(PW);
    localparam int PORTAW = 2;

    typedef enum logic [1:0] {
        K_DATA = 2'd0,
        K_FSEL = 2'd1,
        K_DIR  = 2'd2,
        K_MODE = 2'd3
    } reg_kind_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_t;

    function automatic int used_bits(int p);
        return (p == NPORT - 1) ? LASTW : PW;
    endfunction

    function automatic logic [TOTAL-1:0] valid_map();
        logic [TOTAL-1:0] m;
        m = '0;
        for (int p = 0; p < NPORT; p++)
            for (int b = 0; b < used_bits(p); b++)
                m[p*PW + b] = 1'b1;
        return m;
    endfunction

    localparam logic [TOTAL-1:0] VALID_PINS = valid_map();
    localparam logic [TOTAL-1:0] NOPULL_PINS = TOTAL'(2'b11) << PW;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int W    = 8,
    parameter int USED = 8,
    parameter int IW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_kind_t     kind,
    input  logic          bit_mode,
    input  logic [IW-1:0] bit_idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  lat,
    output logic [W-1:0]  fsel,
    output logic [W-1:0]  dir,
    output logic [W-1:0]  mode
);
    localparam logic [W-1:0] MASK = W'((1 << USED) - 1);

    logic [W-1:0] bsel;
    logic [W-1:0] cur;
    logic [W-1:0] nxt;

    assign bsel = W'(1) << bit_idx;

    always_comb begin
        unique case (kind)
            K_DATA: cur = lat;
            K_FSEL: cur = fsel;
            K_DIR:  cur = dir;
            K_MODE: cur = mode;
            default: cur = '0;
        endcase
        if (bit_mode)
            nxt = ((cur & ~bsel) | (bsel & {W{wdata[0]}})) & MASK;
        else
            nxt = wdata & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat  <= '0;
            fsel <= '0;
            dir  <= '0;
            mode <= '0;
        end else if (wr_en) begin
            unique case (kind)
                K_DATA: lat  <= nxt;
                K_FSEL: fsel <= nxt;
                K_DIR:  dir  <= nxt;
                K_MODE: mode <= nxt;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_hold_fsm.sv
module gpio_hold_fsm
    import gpio_pkg::*;
#(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold_in,
    input  logic [N-1:0] live_oe,
    input  logic [N-1:0] live_out,
    output logic [N-1:0] eff_oe,
    output logic [N-1:0] eff_out
);
    hold_state_t state, state_nxt;
    logic [N-1:0] snap_oe;
    logic [N-1:0] snap_out;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN:  if (hold_in)  state_nxt = ST_HOLD;
            ST_HOLD: if (!hold_in) state_nxt = ST_RUN;
            default: state_nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_RUN;
            snap_oe  <= '0;
            snap_out <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_RUN && hold_in) begin
                snap_oe  <= live_oe;
                snap_out <= live_out;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN: begin
                eff_oe  = live_oe;
                eff_out = live_out;
            end
            ST_HOLD: begin
                eff_oe  = snap_oe;
                eff_out = snap_out;
            end
            default: begin
                eff_oe  = live_oe;
                eff_out = live_out;
            end
        endcase
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic               bus_bit,
    input  logic               bus_rmw,
    input  logic [3:0]         bus_addr,
    input  logic [IDXW-1:0]    bus_bit_idx,
    input  logic [PW-1:0]      bus_wdata,
    output logic [PW-1:0]      bus_rdata,
    input  logic               hold_in,
    input  logic [TOTAL-1:0]   pad_in,
    output logic [TOTAL-1:0]   pad_oe,
    output logic [TOTAL-1:0]   pad_out,
    output logic [TOTAL-1:0]   pull_en,
    output logic [TOTAL-1:0]   pull_up,
    input  logic [TOTAL-1:0]   periph_oe,
    input  logic [TOTAL-1:0]   periph_out,
    output logic [TOTAL-1:0]   periph_in
);
    localparam int POLPORT = NPORT;

    reg_kind_t            kind;
    logic [PORTAW-1:0]    port;
    logic [TOTAL-1:0]     pin_sync;
    logic [TOTAL-1:0]     lat_flat, fsel_flat, dir_flat, mode_flat;
    logic [TOTAL-1:0]     live_oe, live_out;
    logic [NPORT-1:0]     pol;
    logic [PW-1:0]        rd_byte;

    assign kind = reg_kind_t'(bus_addr[3:2]);
    assign port = bus_addr[PORTAW-1:0];
    assign periph_in = pad_in;

    gpio_sync #(.W(TOTAL)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (pin_sync)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic wr_p;
        logic [PW-1:0] sel_s, dir_s;
        assign wr_p = bus_en && bus_wr && (port == PORTAW'(p));

        gpio_port_regs #(.W(PW), .USED(used_bits(p)), .IW(IDXW)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_p),
            .kind    (kind),
            .bit_mode(bus_bit),
            .bit_idx (bus_bit_idx),
            .wdata   (bus_wdata),
            .lat     (lat_flat[p*PW +: PW]),
            .fsel    (fsel_flat[p*PW +: PW]),
            .dir     (dir_flat[p*PW +: PW]),
            .mode    (mode_flat[p*PW +: PW])
        );

        assign sel_s = fsel_flat[p*PW +: PW];
        assign dir_s = dir_flat[p*PW +: PW];
        assign live_oe[p*PW +: PW]  = (sel_s & periph_oe[p*PW +: PW]) | (~sel_s & dir_s);
        assign live_out[p*PW +: PW] = ((sel_s & periph_out[p*PW +: PW]) |
                                       (~sel_s & lat_flat[p*PW +: PW])) &
                                      VALID_PINS[p*PW +: PW];
        assign pull_up[p*PW +: PW]  = {PW{~pol[p]}} & VALID_PINS[p*PW +: PW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol <= '0;
        end else if (bus_en && bus_wr && port == PORTAW'(POLPORT) && kind == K_DATA) begin
            if (!bus_bit)
                pol <= bus_wdata[NPORT-1:0];
            else if (int'(bus_bit_idx) < NPORT)
                pol[bus_bit_idx] <= bus_wdata[0];
        end
    end

    gpio_hold_fsm #(.N(TOTAL)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_in (hold_in),
        .live_oe (live_oe),
        .live_out(live_out),
        .eff_oe  (pad_oe),
        .eff_out (pad_out)
    );

    assign pull_en = ~pad_oe & ~mode_flat & VALID_PINS & ~NOPULL_PINS;

    always_comb begin
        rd_byte = '0;
        if (port == PORTAW'(POLPORT)) begin
            if (kind == K_DATA)
                rd_byte = PW'(pol);
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (port == PORTAW'(p)) begin
                    unique case (kind)
                        K_DATA: rd_byte = bus_rmw ? lat_flat[p*PW +: PW]
                                                  : (pin_sync[p*PW +: PW] & VALID_PINS[p*PW +: PW]);
                        K_FSEL: rd_byte = fsel_flat[p*PW +: PW];
                        K_DIR:  rd_byte = dir_flat[p*PW +: PW];
                        K_MODE: rd_byte = mode_flat[p*PW +: PW];
                        default: rd_byte = '0;
                    endcase
                end
            end
        end
        if (!bus_en)
            bus_rdata = '0;
        else if (bus_bit)
            bus_rdata = PW'(rd_byte[bus_bit_idx]);
        else
            bus_rdata = rd_byte;
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_wr,
    input logic             bus_bit,
    input logic             bus_rmw,
    input logic [3:0]       bus_addr,
    input logic [PW-1:0]    bus_rdata,
    input logic             hold_in,
    input logic [TOTAL-1:0] pad_in,
    input logic [TOTAL-1:0] pad_oe,
    input logic [TOTAL-1:0] pad_out,
    input logic [TOTAL-1:0] pull_en,
    input logic [TOTAL-1:0] lat_flat
);
    logic [TOTAL-1:0] pin_d1, pin_d2;
    logic [1:0]       cyc;
    logic [PW-1:0]    exp_pin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_d1 <= '0;
            pin_d2 <= '0;
            cyc    <= '0;
        end else begin
            pin_d1 <= pad_in;
            pin_d2 <= pin_d1;
            if (cyc != 2'd3) cyc <= cyc + 2'd1;
        end
    end

    always_comb begin
        exp_pin = '0;
        for (int p = 0; p < NPORT; p++)
            if (bus_addr[1:0] == 2'(p))
                exp_pin = pin_d2[p*PW +: PW] & VALID_PINS[p*PW +: PW];
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pull_en == (VALID_PINS & ~NOPULL_PINS)));

    // R4
    bit_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_bit && bus_addr[3:2] == 2'd0 && bus_addr[1:0] != 2'd3)
        |=> ($countones(lat_flat ^ $past(lat_flat)) <= 1));

    // R7
    pin_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3 && bus_en && !bus_wr && !bus_bit && !bus_rmw &&
         bus_addr[3:2] == 2'd0 && bus_addr[1:0] != 2'd3) |-> (bus_rdata == exp_pin));

    // R9
    pull_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_en & pad_oe) == '0);

    // R12
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_in && $past(hold_in)) |-> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_bank gpio_bank_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_wr   (bus_wr),
    .bus_bit  (bus_bit),
    .bus_rmw  (bus_rmw),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .hold_in  (hold_in),
    .pad_in   (pad_in),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out),
    .pull_en  (pull_en),
    .lat_flat (lat_flat)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
    import gpio_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_en = 0, bus_wr = 0, bus_bit = 0, bus_rmw = 0;
    logic [3:0] bus_addr = '0;
    logic [2:0] bus_bit_idx = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic hold_in = 0;
    logic [23:0] pad_in = '0, pad_oe, pad_out, pull_en, pull_up;
    logic [23:0] periph_oe = '0, periph_out = '0, periph_in;

    int total = 0, bad = 0;
    logic [7:0] m_reg[4][3];
    logic [2:0] m_pol;

    gpio_bank uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pmask(int p);
        return (p == 2) ? 8'h1f : 8'hff;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] e_oe();
        logic [23:0] r = '0;
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 8; b++)
                if (pmask(p)[b])
                    r[p*8+b] = m_reg[1][p][b] ? periph_oe[p*8+b] : m_reg[2][p][b];
        return r;
    endfunction

    function automatic logic [23:0] e_out();
        logic [23:0] r = '0;
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 8; b++)
                if (pmask(p)[b])
                    r[p*8+b] = m_reg[1][p][b] ? periph_out[p*8+b] : m_reg[0][p][b];
        return r;
    endfunction

    function automatic logic [23:0] e_pe(logic [23:0] oe);
        logic [23:0] r = '0;
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 8; b++)
                if (pmask(p)[b] && !(p == 1 && b < 2))
                    r[p*8+b] = !oe[p*8+b] && !m_reg[3][p][b];
        return r;
    endfunction

    function automatic logic [23:0] e_pu();
        logic [23:0] r = '0;
        for (int p = 0; p < 3; p++)
            for (int b = 0; b < 8; b++)
                if (pmask(p)[b]) r[p*8+b] = !m_pol[p];
        return r;
    endfunction

    task automatic check_pads(string tag);
        chk({tag, " R5/R6 pad_oe"}, 32'(pad_oe), 32'(e_oe()));
        chk({tag, " R5/R6 pad_out"}, 32'(pad_out), 32'(e_out()));
        chk({tag, " R9/R10 pull_en"}, 32'(pull_en), 32'(e_pe(e_oe())));
        chk({tag, " R11 pull_up"}, 32'(pull_up), 32'(e_pu()));
        chk({tag, " R6 periph_in"}, 32'(periph_in), 32'(pad_in));
    endtask

    task automatic m_wr(int kind, int port, bit bm, int idx, logic [7:0] d);
        logic [7:0] nv;
        if (port == 3) begin
            if (kind == 0) begin
                if (!bm) m_pol = d[2:0];
                else if (idx < 3) m_pol[idx] = d[0];
            end
        end else begin
            nv = m_reg[kind][port];
            if (bm) nv[idx] = d[0];
            else nv = d;
            m_reg[kind][port] = nv & pmask(port);
        end
    endtask

    task automatic wr(int kind, int port, bit bm, int idx, logic [7:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_bit = bm; bus_rmw = 0;
        bus_addr = {2'(kind), 2'(port)}; bus_bit_idx = 3'(idx); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0; bus_bit = 0;
        m_wr(kind, port, bm, idx, d);
    endtask

    task automatic rd(int kind, int port, bit bm, int idx, bit rmw, output logic [7:0] q);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_bit = bm; bus_rmw = rmw;
        bus_addr = {2'(kind), 2'(port)}; bus_bit_idx = 3'(idx);
        #1 q = bus_rdata;
        bus_en = 0; bus_bit = 0; bus_rmw = 0;
    endtask

    function automatic logic [7:0] e_rd(int kind, int port, bit bm, int idx, bit rmw);
        logic [7:0] v;
        if (port == 3) v = (kind == 0) ? {5'b0, m_pol} : 8'h00;
        else if (kind == 0 && !rmw) v = pad_in[port*8 +: 8] & pmask(port);
        else v = m_reg[kind][port];
        return bm ? {7'b0, v[idx]} : v;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] q;
        logic [23:0] s_oe, s_out;
        void'($urandom(32'h1234abcd));
        for (int k = 0; k < 4; k++) for (int p = 0; p < 3; p++) m_reg[k][p] = '0;
        m_pol = '0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 pad_oe", 32'(pad_oe), 32'h0);
        chk("R1 pull_en", 32'(pull_en), 32'h1ffcff);
        chk("R1 pull_up", 32'(pull_up), 32'h1fffff);
        rd(2, 0, 0, 0, 0, q); chk("R1 dir0", 32'(q), 32'h0);
        rd(0, 1, 0, 0, 1, q); chk("R1 lat1", 32'(q), 32'h0);
        rd(0, 3, 0, 0, 0, q); chk("R1 pol", 32'(q), 32'h0);

        // R2 R5 direction and latch
        wr(2, 0, 0, 0, 8'hA5); wr(0, 0, 0, 0, 8'h3C);
        check_pads("R5 dir");
        rd(2, 0, 0, 0, 0, q); chk("R2 dir0 rb", 32'(q), 32'hA5);
        wr(3, 1, 0, 0, 8'h77);
        rd(3, 1, 0, 0, 0, q); chk("R2 mode1 rb", 32'(q), 32'h77);
        wr(1, 3, 0, 0, 8'hFF);
        rd(1, 3, 0, 0, 0, q); chk("R2 unused addr", 32'(q), 32'h0);

        // R3 port 2 upper bits
        wr(2, 2, 0, 0, 8'hFF);
        rd(2, 2, 0, 0, 0, q); chk("R3 dir2", 32'(q), 32'h1F);
        wr(0, 2, 1, 6, 8'h01);
        rd(0, 2, 0, 0, 1, q); chk("R3 lat2 bit6", 32'(q), 32'h0);
        check_pads("R3 pads");

        // R4 bit access
        wr(2, 1, 1, 3, 8'h01);
        rd(2, 1, 0, 0, 0, q); chk("R4 bit wr", 32'(q), 32'h08);
        rd(2, 1, 1, 3, 0, q); chk("R4 bit rd", 32'(q), 32'h01);
        wr(2, 1, 1, 3, 8'hFE);
        rd(2, 1, 0, 0, 0, q); chk("R4 bit clr", 32'(q), 32'h00);

        // R9 R10 R11
        wr(2, 0, 0, 0, 8'h00); wr(3, 0, 0, 0, 8'h0F); wr(3, 1, 0, 0, 8'h00);
        check_pads("R9 mode");
        chk("R10 p1 low pulls", 32'(pull_en[9:8]), 32'h0);
        wr(0, 3, 0, 0, 8'h02);
        check_pads("R11 pol");
        chk("R11 port1 down", 32'(pull_up[15:8]), 32'h0);

        // R6 peripheral select
        periph_oe = 24'h5A_C3_96; periph_out = 24'h0F_F0_33;
        wr(1, 0, 0, 0, 8'hF0); wr(1, 2, 0, 0, 8'hFF);
        check_pads("R6 fsel");

        // R7 R8 pin reads
        wr(0, 0, 0, 0, 8'h81);
        @(negedge clk); pad_in = 24'h123456;
        #1 bus_en = 1; bus_addr = 4'h0;
        #1 chk("R7 no early", 32'(bus_rdata), 32'h00);
        bus_en = 0;
        repeat (2) @(posedge clk);
        rd(0, 0, 0, 0, 0, q); chk("R7 p0", 32'(q), 32'h56);
        rd(0, 1, 0, 0, 0, q); chk("R7 p1", 32'(q), 32'h34);
        rd(0, 2, 0, 0, 0, q); chk("R7 p2", 32'(q), 32'h12);
        rd(0, 0, 0, 0, 1, q); chk("R8 rmw p0", 32'(q), 32'h81);

        // R12 hold
        wr(1, 0, 0, 0, 8'h00); wr(2, 0, 0, 0, 8'h0F);
        @(negedge clk);
        s_oe = pad_oe; s_out = pad_out;
        hold_in = 1;
        wr(2, 0, 0, 0, 8'hF0); wr(0, 0, 0, 0, 8'h7E);
        periph_oe = ~periph_oe;
        chk("R12 frozen oe", 32'(pad_oe), 32'(s_oe));
        chk("R12 frozen out", 32'(pad_out), 32'(s_out));
        rd(2, 0, 0, 0, 0, q); chk("R12 rb in hold", 32'(q), 32'hF0);
        @(negedge clk); hold_in = 0;
        #1 chk("R12 before edge", 32'(pad_oe), 32'(s_oe));
        @(negedge clk);
        check_pads("R12 resumed");

        // random
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 4;
            int kd = $urandom % 4;
            int pt = $urandom % 4;
            int ix = $urandom % 8;
            logic [7:0] d = 8'($urandom);
            if (op == 0) wr(kd, pt, 0, 0, d);
            else if (op == 1) wr(kd, pt, 1, ix, d);
            else if (op == 2) begin
                @(negedge clk); pad_in = 24'($urandom);
                repeat (2) @(posedge clk);
            end else begin
                @(negedge clk); periph_oe = 24'($urandom); periph_out = 24'($urandom);
            end
            @(negedge clk);
            check_pads("rand");
            kd = $urandom % 4; pt = $urandom % 4; ix = $urandom % 8;
            begin
                bit bm = 1'($urandom);
                bit rm = (op == 2) ? 1'b0 : 1'b1;
                rd(kd, pt, bm, ix, rm, q);
                chk((kd == 0 && !rm) ? "R7 rand rd" : "R2/R4/R8 rand rd",
                    32'(q), 32'(e_rd(kd, pt, bm, ix, rm)));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule